// File: doc/BRIEF.md
# Serial Flash Status and Write-Guard Unit

This block is the status and write-permission keeper of a serial flash slave. The serial front end hands it one strobe per completed instruction, carrying the instruction code, the 24-bit-style target address trimmed to the array width, and one data byte. The block also sees the level of the active-low write-protect pin. It answers each strobe, one cycle later, with an accepted or ignored pulse, and keeps an eight-bit status word that the front end shifts out on a status read.

Program and erase instructions pass only when the write latch is set, the target lies outside the range fenced off by the two protection bits, and no earlier operation is still running. An accepted one leaves as a single-cycle request to the memory model and starts a self-timed busy window whose length depends on the operation. Status writes need an arming instruction directly before them, and a lock bit, held in place by the pin, can freeze the protection bits. Sequential auto-increment programming keeps its own address pointer and leaves the mode by itself at the highest address not fenced off.

Top module: `flash_guard`

## Requirements
- R1: After reset the status word reads 0x0C: bit 0 busy, bit 1 write latch, bits 3:2 protection level (reset 11), bits 5:4 always 0, bit 6 auto-increment mode, bit 7 lock; the accepted, ignored and request outputs are low.
- R2: Code 06h sets the write latch; code 04h clears both the write latch and the auto-increment bit.
- R3: Code 01h loads bit 7 into the lock and bits 3:2 into the protection level only when the instruction accepted just before it was 50h; otherwise it is ignored and the status word is unchanged.
- R4: With the pin low and the lock at 1, code 01h is ignored and the lock stays 1; with the pin low and the lock at 0 it may set the lock; with the pin high the lock and the protection bits can be written freely, including clearing the lock.
- R5: Protection level 00 fences nothing, 01 fences the top quarter of the array (30000h upward at the default width), 10 the top half (20000h upward), 11 the whole array; program (02h), sector erase (20h), block erase (52h) and auto-increment program (AFh) aimed inside the fence are ignored.
- R6: Chip erase (60h) is accepted only when the protection level is 00.
- R7: Program and erase codes are ignored while the write latch is 0.
- R8: An accepted program or erase raises the request output for exactly one cycle with a kind code (0 byte program, 1 sector, 2 block, 3 chip), the address (low 12 bits cleared for a sector, low 15 bits for a block, zero for chip) and the data byte (FFh for erases).
- R9: Busy rises with the request and stays high for the per-kind parameter number of cycles; when it falls, the write latch clears for a byte program and every erase.
- R10: While busy is 1, only the status read (05h) is accepted; every other code is ignored and changes nothing.
- R11: The first accepted AFh programs at its own address and sets the auto-increment bit with the write latch kept; each later AFh ignores its address field and programs at the previous address plus one.
- R12: An AFh that programs the highest address outside the fence ends auto-increment mode and clears the write latch when its busy window ends.
- R13: Each strobe yields exactly one of accepted or ignored in the following cycle; reads (03h, 0Bh, 90h, ABh), 05h, 04h and 50h are accepted when idle, unknown codes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe for a completed instruction |
| op_code | input | 8 | Instruction code |
| op_addr | input | AW | Target address |
| op_data | input | 8 | Data byte of the instruction |
| wp_n | input | 1 | Write-protect pin level, active low |
| status_byte | output | 8 | Status word |
| op_accepted | output | 1 | Instruction was acted on |
| op_ignored | output | 1 | Instruction was dropped |
| mem_req | output | 1 | Single-cycle program or erase request |
| mem_kind | output | 2 | Request kind |
| mem_addr | output | AW | Request address |
| mem_data | output | 8 | Request data byte |

## Verification
Assertions watch on every cycle that a request never appears without acceptance, a set write latch the cycle before, and busy rising with it; that non-status codes issued while busy are dropped; that chip erase never leaves under a nonzero protection level; that a pin-held lock cannot fall; and that the busy counter ends cleanly. Which codes arm a status write, the exact protection boundaries, sector and block alignment, the length of each busy window and the auto-increment pointer walk up to the fence can only be shown by the bench's instruction sequences.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_FREAD = 8'h0B;
  localparam logic [7:0] OP_SECT  = 8'h20;
  localparam logic [7:0] OP_EWSR  = 8'h50;
  localparam logic [7:0] OP_BLK   = 8'h52;
  localparam logic [7:0] OP_CHIP  = 8'h60;
  localparam logic [7:0] OP_ID0   = 8'h90;
  localparam logic [7:0] OP_ID1   = 8'hAB;
  localparam logic [7:0] OP_AAI   = 8'hAF;

  typedef enum logic [1:0] {
    MK_PROG = 2'd0,
    MK_SECT = 2'd1,
    MK_BLK  = 2'd2,
    MK_CHIP = 2'd3
  } mem_kind_e;

endpackage

// File: rtl/fg_protect.sv
module fg_protect #(
  parameter int AW = 18
) (
  input  logic [1:0]    bp,
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [AW-1:0] top_free
);
  always_comb begin
    case (bp)
      2'b00: begin
        hit      = 1'b0;
        top_free = '1;
      end
      2'b01: begin
        hit      = addr[AW-1] & addr[AW-2];
        top_free = {2'b10, {(AW-2){1'b1}}};
      end
      2'b10: begin
        hit      = addr[AW-1];
        top_free = {1'b0, {(AW-1){1'b1}}};
      end
      default: begin
        hit      = 1'b1;
        top_free = '0;
      end
    endcase
  end
endmodule

// File: rtl/fg_busy_timer.sv
module fg_busy_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      cnt_q <= load;
      busy  <= 1'b1;
    end else if (busy) begin
      cnt_q <= cnt_q - CW'(1);
      busy  <= (cnt_q != CW'(1));
    end
  end

  assign done = busy && (cnt_q == CW'(1));

  // R9
  timer_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R9
  timer_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
endmodule

// File: rtl/fg_status_word.sv
module fg_status_word (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wp_n,
  output logic [1:0] bp,
  output logic       lock,
  output logic       wr_ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bp   <= 2'b11;
      lock <= 1'b0;
    end else if (wr_en && wr_ok) begin
      bp   <= wr_data[3:2];
      lock <= wr_data[7];
    end
  end

  assign wr_ok = wp_n || !lock;

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wp_n && lock) |=> (lock && $stable(bp)));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int AW       = 18,
  parameter int PROG_CYC = 6,
  parameter int SECT_CYC = 10,
  parameter int BLK_CYC  = 14,
  parameter int CHIP_CYC = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [7:0]    op_code,
  input  logic [AW-1:0] op_addr,
  input  logic [7:0]    op_data,
  input  logic          wp_n,
  output logic [7:0]    status_byte,
  output logic          op_accepted,
  output logic          op_ignored,
  output logic          mem_req,
  output logic [1:0]    mem_kind,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data
);
  localparam int MAX_AB = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_CD = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = $clog2(MAXC + 1);
  localparam int SECT_LSB = 12;
  localparam int BLK_LSB  = 15;

  logic          wel_q, aai_q, arm_q, pend_wel_q, pend_aai_q;
  logic [AW-1:0] ptr_q;
  logic          busy, done;
  logic [1:0]    bp;
  logic          lock, wr_ok;
  logic          op_hit, ptr_hit;
  logic [AW-1:0] top_free, top_free_unused;

  // decision signals
  logic          acc, start, set_wel, clr_wel, set_aai, clr_aai, wr_go;
  logic          fin_wel, fin_aai, step_ptr;
  logic [CW-1:0] load;
  mem_kind_e     kind;
  logic [AW-1:0] tgt, nxt_ptr;
  logic [7:0]    dat;

  fg_protect #(.AW(AW)) u_prot_op (
    .bp(bp), .addr(op_addr), .hit(op_hit), .top_free(top_free));

  fg_protect #(.AW(AW)) u_prot_ptr (
    .bp(bp), .addr(ptr_q), .hit(ptr_hit), .top_free(top_free_unused));

  fg_busy_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .start(start), .load(load),
    .busy(busy), .done(done));

  fg_status_word u_sw (
    .clk(clk), .rst(rst), .wr_en(wr_go), .wr_data(op_data), .wp_n(wp_n),
    .bp(bp), .lock(lock), .wr_ok(wr_ok));

  always_comb begin
    acc      = 1'b0;
    start    = 1'b0;
    load     = '0;
    kind     = MK_PROG;
    tgt      = op_addr;
    dat      = 8'hFF;
    set_wel  = 1'b0;
    clr_wel  = 1'b0;
    set_aai  = 1'b0;
    clr_aai  = 1'b0;
    wr_go    = 1'b0;
    fin_wel  = 1'b0;
    fin_aai  = 1'b0;
    step_ptr = 1'b0;
    nxt_ptr  = ptr_q;
    if (op_valid) begin
      if (busy) begin
        acc = (op_code == OP_RDSR);
      end else begin
        case (op_code)
          OP_RDSR, OP_READ, OP_FREAD, OP_ID0, OP_ID1, OP_EWSR: acc = 1'b1;
          OP_WREN: begin
            acc     = 1'b1;
            set_wel = 1'b1;
          end
          OP_WRDI: begin
            acc     = 1'b1;
            clr_wel = 1'b1;
            clr_aai = 1'b1;
          end
          OP_WRSR: begin
            if (arm_q && wr_ok) begin
              acc   = 1'b1;
              wr_go = 1'b1;
            end
          end
          OP_PROG: begin
            if (wel_q && !op_hit) begin
              acc     = 1'b1;
              start   = 1'b1;
              load    = CW'(PROG_CYC);
              dat     = op_data;
              fin_wel = 1'b1;
            end
          end
          OP_SECT: begin
            if (wel_q && !op_hit) begin
              acc     = 1'b1;
              start   = 1'b1;
              load    = CW'(SECT_CYC);
              kind    = MK_SECT;
              tgt     = {op_addr[AW-1:SECT_LSB], {SECT_LSB{1'b0}}};
              fin_wel = 1'b1;
            end
          end
          OP_BLK: begin
            if (wel_q && !op_hit) begin
              acc     = 1'b1;
              start   = 1'b1;
              load    = CW'(BLK_CYC);
              kind    = MK_BLK;
              tgt     = {op_addr[AW-1:BLK_LSB], {BLK_LSB{1'b0}}};
              fin_wel = 1'b1;
            end
          end
          OP_CHIP: begin
            if (wel_q && bp == 2'b00) begin
              acc     = 1'b1;
              start   = 1'b1;
              load    = CW'(CHIP_CYC);
              kind    = MK_CHIP;
              tgt     = '0;
              fin_wel = 1'b1;
            end
          end
          OP_AAI: begin
            if (!aai_q) begin
              if (wel_q && !op_hit) begin
                acc      = 1'b1;
                start    = 1'b1;
                load     = CW'(PROG_CYC);
                dat      = op_data;
                set_aai  = 1'b1;
                step_ptr = 1'b1;
                nxt_ptr  = op_addr + AW'(1);
                fin_wel  = (op_addr == top_free);
                fin_aai  = (op_addr == top_free);
              end
            end else if (wel_q && !ptr_hit) begin
              acc      = 1'b1;
              start    = 1'b1;
              load     = CW'(PROG_CYC);
              tgt      = ptr_q;
              dat      = op_data;
              step_ptr = 1'b1;
              nxt_ptr  = ptr_q + AW'(1);
              fin_wel  = (ptr_q == top_free);
              fin_aai  = (ptr_q == top_free);
            end
          end
          default: acc = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q       <= 1'b0;
      aai_q       <= 1'b0;
      arm_q       <= 1'b0;
      pend_wel_q  <= 1'b0;
      pend_aai_q  <= 1'b0;
      ptr_q       <= '0;
      op_accepted <= 1'b0;
      op_ignored  <= 1'b0;
      mem_req     <= 1'b0;
      mem_kind    <= 2'd0;
      mem_addr    <= '0;
      mem_data    <= 8'h00;
    end else begin
      op_accepted <= acc;
      op_ignored  <= op_valid && !acc;
      mem_req     <= start;
      if (start) begin
        mem_kind   <= kind;
        mem_addr   <= tgt;
        mem_data   <= dat;
        pend_wel_q <= fin_wel;
        pend_aai_q <= fin_aai;
      end
      if (step_ptr) ptr_q <= nxt_ptr;
      if (op_valid) arm_q <= !busy && (op_code == OP_EWSR);
      if (set_wel) wel_q <= 1'b1;
      else if (clr_wel || (done && pend_wel_q)) wel_q <= 1'b0;
      if (set_aai) aai_q <= 1'b1;
      else if (clr_aai || (done && pend_aai_q)) aai_q <= 1'b0;
    end
  end

  assign status_byte = {lock, aai_q, 2'b00, bp, wel_q, busy};

  // R13
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    !(op_accepted && op_ignored));

  // R8
  req_acc_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> op_accepted);

  // R9
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R7
  req_wel_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $past(wel_q));

  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && busy && op_code != OP_RDSR) |=> (op_ignored && !mem_req));

  // R6
  chip_fence_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CHIP && bp != 2'b00) |=> !mem_req);
endmodule

// File: tb/flash_guard_test.sv
module flash_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 18;
  localparam int PC   = 6;
  localparam int SC   = 10;
  localparam int BC   = 14;
  localparam int CC   = 18;
  localparam int SETTLE = 24;
  localparam int NV   = 32;

  // {wp_n, code, addr, data, expect_accept, expect_status_after}
  localparam logic [43:0] TBL [0:NV-1] = '{
    {1'b1, 8'h05, 18'h00000, 8'h00, 1'b1, 8'h0C},
    {1'b1, 8'h06, 18'h00000, 8'h00, 1'b1, 8'h0E},
    {1'b1, 8'h02, 18'h00100, 8'h55, 1'b0, 8'h0E},
    {1'b1, 8'h01, 18'h00000, 8'h00, 1'b0, 8'h0E},
    {1'b1, 8'h50, 18'h00000, 8'h00, 1'b1, 8'h0E},
    {1'b1, 8'h01, 18'h00000, 8'h04, 1'b1, 8'h06},
    {1'b1, 8'h02, 18'h30000, 8'h12, 1'b0, 8'h06},
    {1'b1, 8'h02, 18'h2FFFF, 8'h12, 1'b1, 8'h04},
    {1'b1, 8'h02, 18'h00010, 8'h12, 1'b0, 8'h04},
    {1'b1, 8'h50, 18'h00000, 8'h00, 1'b1, 8'h04},
    {1'b1, 8'h03, 18'h00000, 8'h00, 1'b1, 8'h04},
    {1'b1, 8'h01, 18'h00000, 8'h00, 1'b0, 8'h04},
    {1'b0, 8'h50, 18'h00000, 8'h00, 1'b1, 8'h04},
    {1'b0, 8'h01, 18'h00000, 8'h88, 1'b1, 8'h88},
    {1'b0, 8'h50, 18'h00000, 8'h00, 1'b1, 8'h88},
    {1'b0, 8'h01, 18'h00000, 8'h00, 1'b0, 8'h88},
    {1'b1, 8'h50, 18'h00000, 8'h00, 1'b1, 8'h88},
    {1'b1, 8'h01, 18'h00000, 8'h00, 1'b1, 8'h00},
    {1'b1, 8'h06, 18'h00000, 8'h00, 1'b1, 8'h02},
    {1'b1, 8'h60, 18'h00000, 8'h00, 1'b1, 8'h00},
    {1'b1, 8'hFF, 18'h00000, 8'h00, 1'b0, 8'h00},
    {1'b1, 8'h06, 18'h00000, 8'h00, 1'b1, 8'h02},
    {1'b1, 8'h04, 18'h00000, 8'h00, 1'b1, 8'h00},
    {1'b1, 8'h60, 18'h00000, 8'h00, 1'b0, 8'h00},
    {1'b1, 8'h50, 18'h00000, 8'h00, 1'b1, 8'h00},
    {1'b1, 8'h01, 18'h00000, 8'h08, 1'b1, 8'h08},
    {1'b1, 8'h06, 18'h00000, 8'h00, 1'b1, 8'h0A},
    {1'b1, 8'h20, 18'h20000, 8'h00, 1'b0, 8'h0A},
    {1'b1, 8'h52, 18'h1F000, 8'h00, 1'b1, 8'h08},
    {1'b1, 8'h06, 18'h00000, 8'h00, 1'b1, 8'h0A},
    {1'b1, 8'h60, 18'h00000, 8'h00, 1'b0, 8'h0A},
    {1'b1, 8'h04, 18'h00000, 8'h00, 1'b1, 8'h08}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [7:0]    op_code = 8'h00;
  logic [AW-1:0] op_addr = '0;
  logic [7:0]    op_data = 8'h00;
  logic          wp_n = 1'b1;
  logic [7:0]    status_byte;
  logic          op_accepted, op_ignored, mem_req;
  logic [1:0]    mem_kind;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  flash_guard #(.AW(AW), .PROG_CYC(PC), .SECT_CYC(SC), .BLK_CYC(BC),
                .CHIP_CYC(CC)) uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_data(op_data), .wp_n(wp_n),
    .status_byte(status_byte), .op_accepted(op_accepted),
    .op_ignored(op_ignored), .mem_req(mem_req), .mem_kind(mem_kind),
    .mem_addr(mem_addr), .mem_data(mem_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [7:0] c,
                       input logic [AW-1:0] a, input logic [7:0] d);
    wp_n     = w;
    op_code  = c;
    op_addr  = a;
    op_data  = d;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    chk(status_byte == 8'h0C, "R1 reset status", status_byte, 8'h0C);
    chk(!op_accepted && !op_ignored && !mem_req, "R1 reset outputs",
        {op_accepted, op_ignored, mem_req}, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R13
    for (int i = 0; i < NV; i++) begin
      issue(TBL[i][43], TBL[i][42:35], TBL[i][34:17], TBL[i][16:9]);
      chk(op_accepted == TBL[i][8] && op_ignored == !TBL[i][8],
          $sformatf("R13 row %0d accept (R3 R4 R5 R6 R7)", i),
          {op_accepted, op_ignored}, {TBL[i][8], !TBL[i][8]});
      idle(SETTLE);
      chk(status_byte == TBL[i][7:0],
          $sformatf("R2 row %0d status (R3 R4 R5 R6)", i),
          status_byte, TBL[i][7:0]);
    end

    // level now 10, latch clear: status 08
    issue(1'b1, 8'h06, '0, 8'h00);
    issue(1'b1, 8'h20, 18'h12345, 8'h77);
    // R8 sector request fields
    chk(mem_req && mem_kind == 2'd1 && mem_addr == 18'h12000 && mem_data == 8'hFF,
        "R8 sector request", {mem_req, mem_kind, mem_addr, mem_data},
        {1'b1, 2'd1, 18'h12000, 8'hFF});
    chk(status_byte == 8'h0B, "R9 busy with request", status_byte, 8'h0B);
    issue(1'b1, 8'h06, '0, 8'h00);
    // R10 dropped while busy, request was single-cycle
    chk(op_ignored && !op_accepted && !mem_req, "R10 code dropped while busy",
        {op_accepted, op_ignored, mem_req}, 3'b010);
    issue(1'b1, 8'h05, '0, 8'h00);
    chk(op_accepted, "R10 status read while busy", op_accepted, 1);
    idle(SC - 3);
    chk(status_byte == 8'h0B, "R9 busy last cycle", status_byte, 8'h0B);
    idle(1);
    chk(status_byte == 8'h08, "R9 busy end clears latch", status_byte, 8'h08);

    // R8 block alignment
    issue(1'b1, 8'h06, '0, 8'h00);
    issue(1'b1, 8'h52, 18'h0ABCD, 8'h00);
    chk(mem_req && mem_kind == 2'd2 && mem_addr == 18'h08000,
        "R8 block request", {mem_req, mem_kind, mem_addr},
        {1'b1, 2'd2, 18'h08000});
    idle(SETTLE);

    // R11 R12 auto-increment up to fence at level 10 (top free 1FFFF)
    issue(1'b1, 8'h06, '0, 8'h00);
    issue(1'b1, 8'hAF, 18'h1FFFE, 8'hA5);
    chk(mem_req && mem_kind == 2'd0 && mem_addr == 18'h1FFFE && mem_data == 8'hA5,
        "R11 first auto program", {mem_req, mem_kind, mem_addr, mem_data},
        {1'b1, 2'd0, 18'h1FFFE, 8'hA5});
    idle(SETTLE);
    chk(status_byte == 8'h4A, "R11 mode kept with latch", status_byte, 8'h4A);
    issue(1'b1, 8'hAF, 18'h00000, 8'h5A);
    chk(mem_req && mem_addr == 18'h1FFFF && mem_data == 8'h5A,
        "R11 next auto address", {mem_req, mem_addr, mem_data},
        {1'b1, 18'h1FFFF, 8'h5A});
    idle(SETTLE);
    chk(status_byte == 8'h08, "R12 exit at fence", status_byte, 8'h08);

    // R2 exit by 04h
    issue(1'b1, 8'h06, '0, 8'h00);
    issue(1'b1, 8'hAF, 18'h00040, 8'h11);
    idle(SETTLE);
    issue(1'b1, 8'hAF, 18'h3FFFF, 8'h22);
    chk(mem_req && mem_addr == 18'h00041, "R11 pointer step", mem_addr, 18'h00041);
    idle(SETTLE);
    chk(status_byte == 8'h4A, "R11 mode after step", status_byte, 8'h4A);
    issue(1'b1, 8'h04, '0, 8'h00);
    chk(status_byte == 8'h08, "R2 clear ends auto mode", status_byte, 8'h08);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule